// File: doc/BRIEF.md
# Packet payload PRBS error checker

This block measures the bit error rate of a byte-wide transport stream made of 188-byte packets. Each packet opens with one sync byte, which is framing only. The 187 bytes after it carry a pseudo-random test sequence. The checker builds the same sequence locally and compares it with every payload byte. Each differing bit adds to an error counter, and each compared byte adds eight to a bit counter. The ratio of the two counters gives the bit error rate.

The checker has no fixed starting state for its sequence. It locks on by loading its register from the first received payload bits. If one packet holds too many errored bytes, it drops lock and loads the register again. Software reads the two counters from plain output ports and zeroes them with a one-cycle clear strobe.

Top module: `prbs_payload_checker`

## Requirements
- R1: After reset, `err_count` and `bit_count` are zero and `locked` is low.
- R2: A byte with `in_valid` and `in_sync` both high is a sync byte. Its value is never compared and the sequence generator holds during it. The next 187 bytes with `in_valid` high and `in_sync` low are payload. Cycles with `in_valid` low have no effect.
- R3: Valid bytes that arrive before the first sync byte, or after the 187th payload byte but before the next sync byte, are ignored.
- R4: The expected sequence comes from a 23-bit register `s` for the polynomial x^23 + x^18 + 1. Each new bit is `s[22] ^ s[17]`, and the register then shifts left with that bit entering at `s[0]`. Eight bits are produced per payload byte, and the first bit produced is the byte's MSB.
- R5: While unlocked, each payload byte is shifted into the register, MSB first, in place of the generated bits. `locked` rises on the third such byte. Counters do not change while unlocked.
- R6: For each payload byte checked while locked, `err_count` grows by the number of bits that differ from the expected byte.
- R7: For each payload byte checked while locked, `bit_count` grows by 8.
- R8: The count of errored bytes in a packet resets at every sync byte. If that count goes past `LOSS_LIMIT` within one packet, `locked` falls on the byte that crossed it, and acquisition (R5) starts again from the next payload byte. Exactly `LOSS_LIMIT` errored bytes keep lock.
- R9: Both counters saturate at their all-ones value.
- R10: `clear` zeroes both counters on the next edge. It takes priority over a count in the same cycle and does not affect `locked`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A stream byte is present |
| in_sync | input | 1 | The present byte is a packet's sync byte |
| in_data | input | 8 | Stream byte |
| clear | input | 1 | Zeroes both counters |
| err_count | output | ERR_W | Saturating count of errored bits |
| bit_count | output | BIT_W | Saturating count of compared bits |
| locked | output | 1 | The generator is aligned to the stream |

## Verification
The bench locks on after exactly three payload bytes and checks that lock comes neither early nor late. A design that miscounted the seed bytes would show lock one byte out, and its bit count would be off by 8. The bench sends a wrong sync value and a stall in the middle of a packet. A design that compared the sync byte, or stepped its generator on idle cycles, would then log errors on a clean stream. The bench also feeds excess bytes before any sync and past the 187th payload byte, which must be ignored. It checks that exactly `LOSS_LIMIT` errored bytes in each of two packets keep lock, while one more drops it and lock is then regained. This catches an off-by-one in the threshold and a missing per-packet reset. The bench also drives both counters into saturation, and applies a clear in the same cycle as a count, to check wrap-around and clear priority.

// File: rtl/prbs_payload_checker.sv
module prbs_payload_checker #(
  parameter int ERR_W      = 32,
  parameter int BIT_W      = 48,
  parameter int LOSS_LIMIT = 16,
  parameter int PKT_BYTES  = 188
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_sync,
  input  logic [7:0]       in_data,
  input  logic             clear,
  output logic [ERR_W-1:0] err_count,
  output logic [BIT_W-1:0] bit_count,
  output logic             locked
);
  localparam int POS_W  = $clog2(PKT_BYTES + 1);
  localparam int BERR_W = $clog2(LOSS_LIMIT + 2);
  localparam logic [ERR_W-1:0] ERR_MAX = '1;
  localparam logic [BIT_W-1:0] BIT_MAX = '1;

  function automatic logic [30:0] step8(input logic [22:0] s);
    logic [7:0] b;
    logic       nb;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      nb = s[22] ^ s[17];
      s  = {s[21:0], nb};
      b  = {b[6:0], nb};
    end
    return {s, b};
  endfunction

  logic [POS_W-1:0]  pos;
  logic [22:0]       lfsr;
  logic [1:0]        seed_cnt;
  logic [BERR_W-1:0] byte_errs;

  logic [30:0] gen;
  logic [7:0]  diff;
  logic [3:0]  nbits;
  logic        sync_b, pay, upd;
  logic [ERR_W:0] err_sum;
  logic [BIT_W:0] bit_sum;

  assign sync_b  = in_valid && in_sync;
  assign pay     = in_valid && !in_sync && (pos < POS_W'(PKT_BYTES));
  assign upd     = pay && locked;
  assign gen     = step8(lfsr);
  assign diff    = in_data ^ gen[7:0];
  assign nbits   = 4'($countones(diff));
  assign err_sum = {1'b0, err_count} + (ERR_W+1)'(nbits);
  assign bit_sum = {1'b0, bit_count} + (BIT_W+1)'(8);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos       <= POS_W'(PKT_BYTES);
      lfsr      <= '0;
      seed_cnt  <= '0;
      byte_errs <= '0;
      locked    <= 1'b0;
    end else if (sync_b) begin
      pos       <= POS_W'(1);
      byte_errs <= '0;
    end else if (pay) begin
      pos <= pos + POS_W'(1);
      if (!locked) begin
        lfsr <= {lfsr[14:0], in_data};
        if (seed_cnt == 2'd2) begin
          seed_cnt <= '0;
          locked   <= 1'b1;
        end else begin
          seed_cnt <= seed_cnt + 2'd1;
        end
      end else begin
        lfsr <= gen[30:8];
        if (diff != 8'h00) begin
          if (byte_errs == BERR_W'(LOSS_LIMIT)) begin
            locked    <= 1'b0;
            seed_cnt  <= '0;
            byte_errs <= '0;
          end else begin
            byte_errs <= byte_errs + BERR_W'(1);
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      err_count <= '0;
      bit_count <= '0;
    end else if (upd) begin
      err_count <= (err_sum > {1'b0, ERR_MAX}) ? ERR_MAX : err_sum[ERR_W-1:0];
      bit_count <= (bit_sum > {1'b0, BIT_MAX}) ? BIT_MAX : bit_sum[BIT_W-1:0];
    end
  end

  // R2
  sync_no_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_b && !clear) |=> ($stable(err_count) && $stable(bit_count)));

  // R3
  idle_no_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && !clear) |=> ($stable(err_count) && $stable(bit_count) && $stable(locked)));

  // R5
  lock_on_payload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(pay));

  // R8
  unlock_on_payload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> $past(pay && diff != 8'h00));

  // R9
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> (err_count >= $past(err_count) && bit_count >= $past(bit_count)));

  // R10
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (err_count == '0 && bit_count == '0));

  // R2
  pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pos <= POS_W'(PKT_BYTES) && pos != '0);
endmodule

// File: tb/prbs_payload_checker_test.sv
`timescale 1ns/1ps
module prbs_payload_checker_test;
  localparam int EW = 6;
  localparam int BW = 12;
  localparam int LIM = 4;

  logic clk = 0;
  logic rst_n = 0;
  logic in_valid = 0, in_sync = 0, clear = 0;
  logic [7:0] in_data = 0;
  logic [EW-1:0] err_count;
  logic [BW-1:0] bit_count;
  logic locked;

  int n_checks = 0;
  int n_fail = 0;
  logic [22:0] tx_s = 23'h5A5A5;

  always #4 clk = ~clk;

  prbs_payload_checker #(.ERR_W(EW), .BIT_W(BW), .LOSS_LIMIT(LIM)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sync(in_sync),
    .in_data(in_data), .clear(clear), .err_count(err_count),
    .bit_count(bit_count), .locked(locked));

  task automatic check(input string req, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] tx_byte();
    logic [7:0] b = 0;
    for (int i = 0; i < 8; i++) begin
      logic nb;
      nb = tx_s[22] ^ tx_s[17];
      tx_s = {tx_s[21:0], nb};
      b = {b[6:0], nb};
    end
    return b;
  endfunction

  task automatic drive(input logic [7:0] d, input logic s);
    @(negedge clk);
    in_valid = 1; in_sync = s; in_data = d;
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 0; in_sync = 0; clear = 0;
  endtask

  task automatic payload(input int n, input logic [7:0] mask, input int nflip);
    for (int i = 0; i < n; i++) begin
      logic [7:0] b;
      b = tx_byte();
      if (i < nflip) b = b ^ mask;
      drive(b, 0);
    end
    idle();
  endtask

  task automatic sync(input logic [7:0] v);
    drive(v, 1);
    idle();
  endtask

  task automatic do_clear();
    @(negedge clk); clear = 1;
    idle();
  endtask

  task automatic t_reset();
    check("R1 err", err_count, 0);
    check("R1 bits", bit_count, 0);
    check("R1 locked", locked, 0);
  endtask

  task automatic t_pre_sync();
    for (int i = 0; i < 10; i++) drive(8'(i * 37), 0);
    idle();
    check("R3 pre-sync locked", locked, 0);
    check("R3 pre-sync bits", bit_count, 0);
  endtask

  task automatic t_acquire();
    sync(8'h47);
    payload(2, 0, 0);
    check("R5 not yet locked", locked, 0);
    payload(1, 0, 0);
    check("R5 locked after 3", locked, 1);
    check("R5 no count while seeding", bit_count, 0);
    payload(100, 0, 0);
    payload(84, 0, 0);
    check("R4 clean stream err", err_count, 0);
    check("R7 bits", bit_count, 1472);
  endtask

  task automatic t_overrun();
    for (int i = 0; i < 5; i++) drive(8'hC3, 0);
    idle();
    check("R3 overrun bits", bit_count, 1472);
    check("R3 overrun err", err_count, 0);
  endtask

  task automatic t_sync_skip();
    sync(8'h00);
    payload(187, 0, 0);
    check("R2 sync skip err", err_count, 0);
    check("R2 sync skip bits", bit_count, 2968);
  endtask

  task automatic t_errors();
    do_clear();
    check("R10 clear err", err_count, 0);
    check("R10 clear bits", bit_count, 0);
    check("R10 lock kept", locked, 1);
    sync(8'h47);
    payload(1, 8'h07, 1);
    payload(1, 8'h80, 1);
    payload(185, 0, 0);
    check("R6 popcount", err_count, 4);
    check("R7 packet bits", bit_count, 1496);
  endtask

  task automatic t_clear_priority();
    sync(8'h47);
    @(negedge clk);
    in_valid = 1; in_sync = 0; in_data = tx_byte() ^ 8'h01; clear = 1;
    idle();
    check("R10 clear priority err", err_count, 0);
    check("R10 clear priority bits", bit_count, 0);
    payload(186, 0, 0);
    check("R7 after clear bits", bit_count, 1488);
  endtask

  task automatic t_err_sat();
    do_clear();
    sync(8'h47);
    payload(187, 8'hFF, 4);
    check("R6 32 bit errors", err_count, 32);
    check("R8 limit keeps lock", locked, 1);
    sync(8'h47);
    payload(187, 8'hFF, 4);
    check("R9 err saturates", err_count, 63);
    check("R8 per-packet reset", locked, 1);
  endtask

  task automatic t_bit_sat();
    do_clear();
    for (int p = 0; p < 3; p++) begin
      sync(8'h47);
      payload(187, 0, 0);
    end
    check("R9 bits saturate", bit_count, 4095);
  endtask

  task automatic t_loss();
    do_clear();
    sync(8'h47);
    payload(5, 8'h01, 5);
    check("R8 lock lost", locked, 0);
    check("R8 err before loss", err_count, 5);
    check("R8 bits before loss", bit_count, 40);
    payload(2, 0, 0);
    check("R5 reseeding", locked, 0);
    payload(1, 0, 0);
    check("R5 relocked", locked, 1);
    payload(179, 0, 0);
    check("R8 err after relock", err_count, 5);
    check("R7 bits after relock", bit_count, 1472);
  endtask

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_pre_sync();
    t_acquire();
    t_overrun();
    t_sync_skip();
    t_errors();
    t_clear_priority();
    t_err_sat();
    t_bit_sat();
    t_loss();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule